// File: doc/BRIEF.md
# DMA Burst Arbiter with Receive Watermark Priority

This block shares one system-bus master port between a transmit DMA engine and a receive DMA engine. At each burst boundary it picks one requester and sets the length of the burst it may issue. The grant then stays with that engine until the burst's beats have been accepted.

Receive can be made urgent by a watermark scheme with hysteresis. Receive becomes urgent once the receive FIFO fill level reaches a high mark. It stays urgent until the level drops below a low mark. Both marks are set in eighths of the FIFO depth.

When receive is not urgent, contention is settled in round-robin order. The burst length is the largest enabled fixed size that fits both the requester's remaining word count and the configured maximum-transfer limit. The bus protocol engine and the FIFOs sit outside the block.

Top module: `dma_burst_arb`

## Requirements
- R1: `cfg_i` fields are as follows. [15:14] is the transfer limit. [9] enables watermark priority. [8:6] is the high mark h and [5:3] is the low mark l. [2], [1] and [0] enable the large, medium and small burst sizes (parameters BURST_L, BURST_M, BURST_S; defaults 16, 8 and 4). Bits [13:10] are ignored.
- R2: With [9] set, receive becomes urgent once the fill level is at least h*FIFO_DEPTH/8. The level is registered, so it affects arbitration from the following cycle.
- R3: Once urgent, receive stays urgent while the level is at least l*FIFO_DEPTH/8. It clears when the level goes below that mark. It is never urgent while [9] is clear.
- R4: If both engines request and receive is not urgent, the grant goes to the engine that did not win the previous grant. After reset, transmit wins the first tie.
- R5: If both engines request and receive is urgent, receive wins. A lone requester always wins. An engine that is not requesting is never granted.
- R6: The burst length is the largest enabled size that does not exceed either the winner's remaining word count or the transfer limit.
- R7: The transfer limit codes are: 0 and 1 mean unlimited, 2 means 32 words, and 3 means 64 words.
- R8: If no enabled size fits, or no size is enabled, the burst length is 1.
- R9: A grant rises one cycle after an idle cycle in which a request is seen. It is held until `beat_i` has been high for burst-length cycles, and it falls in the cycle after the last beat. At least one idle cycle separates bursts, and arbitration happens only in idle cycles.
- R10: At most one grant is high at a time. `burst_len_o` is 0 whenever no grant is high.
- R11: During and after reset, both grants are low and `burst_len_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 16 | Arbitration and burst configuration word |
| tx_req_i | input | 1 | Transmit DMA requests the bus |
| tx_words_i | input | CNT_W | Transmit words remaining |
| rx_req_i | input | 1 | Receive DMA requests the bus |
| rx_words_i | input | CNT_W | Receive words remaining |
| rx_level_i | input | LVL_W | Receive FIFO fill level, 0..FIFO_DEPTH |
| beat_i | input | 1 | Bus accepted one beat of the current burst |
| tx_gnt_o | output | 1 | Transmit owns the bus |
| rx_gnt_o | output | 1 | Receive owns the bus |
| burst_len_o | output | LEN_W | Beats in the granted burst |

## Verification
Two functions can meet in the same idle cycle: the watermark state decides the winner, and the round-robin pointer decides it when receive is not urgent. The bench walks the fill level across both marks and back. After each step it raises both requests twice in a row. A bench model of the hysteresis state and the last winner predicts the outcome, so an urgent receive must win both times and a calm one must alternate. The length sweep crosses every limit code with every size-enable mask and with word counts just below, at and above each size. Beats are spaced with gaps so that the grant is seen to hold until the last beat.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef struct packed {
    logic [1:0] max_sel;
    logic [3:0] rsv;
    logic       prio_en;
    logic [2:0] hi_mark;
    logic [2:0] lo_mark;
    logic [2:0] size_en;  // [2]=large [1]=medium [0]=small
  } arb_cfg_t;

  localparam int unsigned LIM_UNLIM = 32'hFFFF_FFFF;

  function automatic int unsigned limit_of(input logic [1:0] sel);
    case (sel)
      2'd2:    limit_of = 32;
      2'd3:    limit_of = 64;
      default: limit_of = LIM_UNLIM;
    endcase
  endfunction

endpackage

// File: rtl/dma_arb_hyst.sv
module dma_arb_hyst #(
  parameter int FIFO_DEPTH = 64,
  parameter int LVL_W      = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [2:0]       hi_i,
  input  logic [2:0]       lo_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             hot_o
);
  localparam int unsigned STEP = FIFO_DEPTH / 8;

  int unsigned hi_lvl, lo_lvl, lvl;
  logic        hot_q;

  always_comb begin
    hi_lvl = 32'(hi_i) * STEP;
    lo_lvl = 32'(lo_i) * STEP;
    lvl    = 32'(level_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hot_q <= 1'b0;
    else if (!en_i)           hot_q <= 1'b0;
    else if (lvl >= hi_lvl)   hot_q <= 1'b1;
    else if (lvl < lo_lvl)    hot_q <= 1'b0;
  end

  assign hot_o = hot_q;

  // R2
  hot_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && lvl >= hi_lvl) |=> hot_o);
  // R3
  hot_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !hot_o);
  // R3
  hot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && lvl >= lo_lvl && lvl < hi_lvl) |=> $stable(hot_o));

endmodule

// File: rtl/dma_arb_sizer.sv
module dma_arb_sizer
  import dma_arb_pkg::*;
#(
  parameter int CNT_W   = 11,
  parameter int BURST_S = 4,
  parameter int BURST_M = 8,
  parameter int BURST_L = 16,
  parameter int LEN_W   = 5
) (
  input  logic [CNT_W-1:0] words_i,
  input  logic [1:0]       max_sel_i,
  input  logic [2:0]       size_en_i,
  output logic [LEN_W-1:0] len_o
);
  localparam int unsigned SIZES [3] = '{BURST_S, BURST_M, BURST_L};

  int unsigned lim;

  // ascending scan: last fitting enabled size is the largest
  always_comb begin
    lim   = limit_of(max_sel_i);
    len_o = LEN_W'(1);
    for (int i = 0; i < 3; i++) begin
      if (size_en_i[i] && SIZES[i] <= 32'(words_i) && SIZES[i] <= lim)
        len_o = LEN_W'(SIZES[i]);
    end
  end

  // R8
  always_comb begin
    len_floor_chk: assert (len_o >= LEN_W'(1));
  end

endmodule

// File: rtl/dma_burst_arb.sv
module dma_burst_arb
  import dma_arb_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = 11,
  parameter int BURST_S    = 4,
  parameter int BURST_M    = 8,
  parameter int BURST_L    = 16,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
  localparam int LEN_W     = $clog2(BURST_L + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [15:0]      cfg_i,
  input  logic             tx_req_i,
  input  logic [CNT_W-1:0] tx_words_i,
  input  logic             rx_req_i,
  input  logic [CNT_W-1:0] rx_words_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             beat_i,
  output logic             tx_gnt_o,
  output logic             rx_gnt_o,
  output logic [LEN_W-1:0] burst_len_o
);
  arb_cfg_t         cfg;
  logic             cfg_unused;
  logic             rx_hot;
  logic [CNT_W-1:0] words_a [2];
  logic [LEN_W-1:0] len_a   [2];

  logic             busy_q, owner_q, last_rx_q;
  logic [LEN_W-1:0] len_q, cnt_q;
  logic             any_req, pick_rx, done;

  assign cfg        = arb_cfg_t'(cfg_i);
  assign cfg_unused = ^cfg.rsv;
  assign words_a[0] = tx_words_i;
  assign words_a[1] = rx_words_i;

  dma_arb_hyst #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_hyst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cfg.prio_en),
    .hi_i    (cfg.hi_mark),
    .lo_i    (cfg.lo_mark),
    .level_i (rx_level_i),
    .hot_o   (rx_hot)
  );

  for (genvar c = 0; c < 2; c++) begin : g_size
    dma_arb_sizer #(
      .CNT_W(CNT_W), .BURST_S(BURST_S), .BURST_M(BURST_M),
      .BURST_L(BURST_L), .LEN_W(LEN_W)
    ) u_sizer (
      .words_i   (words_a[c]),
      .max_sel_i (cfg.max_sel),
      .size_en_i (cfg.size_en),
      .len_o     (len_a[c])
    );
  end

  assign any_req = tx_req_i | rx_req_i;
  assign pick_rx = rx_req_i & (~tx_req_i | rx_hot | ~last_rx_q);
  assign done    = busy_q & beat_i & (cnt_q == len_q - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      owner_q   <= 1'b0;
      last_rx_q <= 1'b1;
      len_q     <= '0;
      cnt_q     <= '0;
    end else if (!busy_q) begin
      if (any_req) begin
        busy_q    <= 1'b1;
        owner_q   <= pick_rx;
        last_rx_q <= pick_rx;
        len_q     <= pick_rx ? len_a[1] : len_a[0];
        cnt_q     <= '0;
      end
    end else if (beat_i) begin
      if (done) busy_q <= 1'b0;
      else      cnt_q  <= cnt_q + LEN_W'(1);
    end
  end

  assign tx_gnt_o    = busy_q & ~owner_q;
  assign rx_gnt_o    = busy_q & owner_q;
  assign burst_len_o = busy_q ? len_q : '0;

  // R10
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_gnt_o, rx_gnt_o}));
  // R10
  len_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_gnt_o | rx_gnt_o) |-> burst_len_o == '0);
  // R5
  tx_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_gnt_o) |-> $past(tx_req_i));
  // R5
  rx_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_gnt_o) |-> $past(rx_req_i));
  // R5
  hot_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && rx_req_i && rx_hot) |=> rx_gnt_o);
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done) |=> $stable(tx_gnt_o) && $stable(rx_gnt_o) && $stable(burst_len_o));
  // R9
  gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !tx_gnt_o && !rx_gnt_o);

endmodule

// File: tb/dma_burst_arb_bench.sv
`timescale 1ns/1ps
module dma_burst_arb_bench;
  localparam int FIFO_DEPTH = 64;
  localparam int CNT_W      = 11;
  localparam int BS = 4, BM = 16, BL = 48;
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
  localparam int LEN_W = $clog2(BL + 1);

  logic             clk = 1'b0, rst_n = 1'b0;
  logic [15:0]      cfg;
  logic             tx_req, rx_req, beat;
  logic [CNT_W-1:0] tx_words, rx_words;
  logic [LVL_W-1:0] level;
  logic             tx_gnt, rx_gnt;
  logic [LEN_W-1:0] blen;

  int total = 0, bad = 0, cyc = 0;
  logic last_rx_m = 1'b1;
  logic hot_m = 1'b0;

  always #2 clk = ~clk;

  dma_burst_arb #(
    .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W),
    .BURST_S(BS), .BURST_M(BM), .BURST_L(BL)
  ) u_dma_burst_arb (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg),
    .tx_req_i(tx_req), .tx_words_i(tx_words),
    .rx_req_i(rx_req), .rx_words_i(rx_words),
    .rx_level_i(level), .beat_i(beat),
    .tx_gnt_o(tx_gnt), .rx_gnt_o(rx_gnt), .burst_len_o(blen)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp<%0d cycles", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_len(input int max_sel, input int en, input int w);
    int lim, r;
    lim = (max_sel == 2) ? 32 : (max_sel == 3) ? 64 : 1 << 30;
    r = 1;
    if (en[0] && BS <= w && BS <= lim) r = BS;
    if (en[1] && BM <= w && BM <= lim) r = BM;
    if (en[2] && BL <= w && BL <= lim) r = BL;
    return r;
  endfunction

  // called at #1 after an edge with the arbiter idle
  task automatic run_burst(input bit t, input bit r, input bit exp_rx,
                           input int elen, input string tag);
    int got = 0, k = 0;
    tx_req = t; rx_req = r;
    @(posedge clk); #1;
    tx_req = 1'b0; rx_req = 1'b0;
    chk(rx_gnt == exp_rx && tx_gnt == !exp_rx, {tag, " winner"}, int'(rx_gnt), int'(exp_rx));
    chk(int'(blen) == elen, {tag, " len"}, int'(blen), elen);
    while (got < elen) begin
      beat = (k % 3) != 2;
      k++;
      @(posedge clk);
      if (beat) got++;
      #1;
      if (got < elen && !(tx_gnt | rx_gnt)) begin
        chk(0, "R9 grant held", 0, 1);
        got = elen;
      end
    end
    beat = 1'b0;
    chk(!tx_gnt && !rx_gnt && blen == '0, "R9 R10 release", int'(tx_gnt | rx_gnt), 0);
    last_rx_m = exp_rx;
  endtask

  task automatic set_level(input int lv);
    level = LVL_W'(lv);
    if (cfg[9]) begin
      if (lv >= 8 * int'(cfg[8:6])) hot_m = 1'b1;
      else if (lv < 8 * int'(cfg[5:3])) hot_m = 1'b0;
    end else hot_m = 1'b0;
    @(posedge clk); @(posedge clk); #1;
  endtask

  initial begin
    cfg = 16'h0007; tx_req = 0; rx_req = 0; beat = 0;
    tx_words = 11'd4; rx_words = 11'd4; level = '0;
    #1;
    // R11
    chk(!tx_gnt && !rx_gnt && blen == '0, "R11 in reset", int'(tx_gnt | rx_gnt), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!tx_gnt && !rx_gnt && blen == '0, "R11 after reset", int'(blen), 0);

    // R4 tie order from reset, alternation
    run_burst(1, 1, 1'b0, 4, "R4 first tie");
    run_burst(1, 1, 1'b1, 4, "R4 tie2");
    run_burst(1, 1, 1'b0, 4, "R4 tie3");
    // R5 lone requester repeats
    run_burst(0, 1, 1'b1, 4, "R5 lone rx");
    run_burst(0, 1, 1'b1, 4, "R5 lone rx again");
    run_burst(1, 0, 1'b0, 4, "R5 lone tx");
    // R1 reserved bits ignored
    cfg = 16'h3C07;
    run_burst(1, 0, 1'b0, 4, "R1 reserved bits");
    // R5 idle with no request: no grant
    @(posedge clk); @(posedge clk); #1;
    chk(!tx_gnt && !rx_gnt, "R5 no request", int'(tx_gnt | rx_gnt), 0);

    // R6 R7 R8 sweep
    for (int ms = 0; ms < 4; ms++)
      for (int en = 0; en < 8; en++)
        foreach (int_words_list[i]) begin
          cfg = 16'(ms << 14) | 16'(en);
          tx_words = CNT_W'(int_words_list[i]);
          run_burst(1, 0, 1'b0, exp_len(ms, en, int_words_list[i]), "R6 R7 R8 sweep");
        end

    // R2 R3 hysteresis vs R4 round robin
    tx_words = 11'd4; rx_words = 11'd4;
    cfg = 16'h0200 | 16'(6 << 6) | 16'(2 << 3) | 16'h0007;
    foreach (int_levels[i]) begin
      set_level(int_levels[i]);
      for (int j = 0; j < 2; j++) begin
        logic e;
        e = hot_m ? 1'b1 : ~last_rx_m;
        run_burst(1, 1, e, 4, hot_m ? "R2 R3 R5 urgent" : "R3 R4 calm");
      end
    end
    // R3 disable with level high
    cfg[9] = 1'b0;
    set_level(63);
    for (int j = 0; j < 2; j++) begin
      logic e;
      e = ~last_rx_m;
      run_burst(1, 1, e, 4, "R3 disabled");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int int_words_list [18] = '{0, 1, 3, 4, 7, 15, 16, 17, 31, 32, 33, 47, 48, 49, 63, 64, 65, 100};
  int int_levels [9] = '{47, 48, 30, 16, 15, 30, 63, 0, 20};

endmodule